// File: doc/BRIEF.md
# Low-Power STOP Mode Controller

This block governs the deepest standby state of a small microcontroller. Software writes a one-byte standby control register. Setting its top bit asks the controller to halt the CPU and gate the oscillator enables. The request is accepted only when no interrupt is waiting. Which clocks are switched off depends on the clock the CPU runs from at that moment. While halted, the I/O pins are either frozen at their last value or floated, as selected by a register bit.

The controller leaves STOP on a reset request or on an external interrupt of sufficient level. Leaving STOP starts a stabilization wait, which counts cycles of the oscillator being restarted, and the CPU is held off until the wait ends. A reset exit waits only when the power-on-reset option input is set. During that wait the reset sequence is held back. After an interrupt exit, an output tells the CPU whether to take the interrupt or to resume at the instruction after the one that entered STOP.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A register write with bit 7 set, made while `cpu_run` is high, `irq_any_pending` is low and `reset_req` is low, enters STOP on that clock edge. `cpu_run` is low from the next cycle on.
- R2: When `irq_any_pending` is high during such a write, STOP is not entered and `cpu_run` stays high. Bits 5 and 3:2 are still loaded.
- R3: STOP entered with `sub_active` low drives `main_clk_en` low and keeps `sub_clk_en` high.
- R4: STOP entered with `sub_active` high drives both `main_clk_en` and `sub_clk_en` low.
- R5: From STOP entry until `cpu_run` returns, register bit 5 = 0 raises `pin_hold` and bit 5 = 1 raises `pin_hiz`. While `cpu_run` is high, both are low.
- R6: In STOP, only `ext_irq_req` together with an `ext_irq_level` of 12 or more (above 11) wakes the block. A lower level, or a level of 12 or more without a request, leaves it in STOP.
- R7: On an interrupt wake, `wake_to_isr` takes the value of `int_accept_ok` sampled at the wake edge. A reset request clears it.
- R8: An interrupt wake from a main-clock STOP waits 2^WAIT_EXP_n `main_tick` pulses, where n is register bits 3:2 (00→n=0, 01→1, 10→2, 11→3). During this wait both clock enables are high.
- R9: An interrupt wake from a subclock STOP waits 2^SUB_WAIT_EXP `sub_tick` pulses. During this wait `main_clk_en` is low and `sub_clk_en` is high.
- R10: `reset_req` in STOP with `por_option` high starts the R8 main-clock wait selected by bits 3:2 held before the reset, with `rst_seq_hold` high throughout. With `por_option` low, `cpu_run` is high on the next cycle.
- R11: `reg_rdata` shows bit 5 and bits 3:2 as written, with every other bit 0 (bit 7 always reads 0). `reset_req` clears the register. Writes made while `cpu_run` is low are ignored.
- R12: After `rst_n`, the outputs are: `cpu_run` = 1, both clock enables = 1, both pin controls = 0, register = 0, `wake_to_isr` = 0, `rst_seq_hold` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Write strobe for the standby control register |
| reg_wdata | input | 8 | Write data: bit 7 stop request, bit 5 pin select, bits 3:2 wait select |
| reg_rdata | output | 8 | Register readback |
| sub_active | input | 1 | 1 when the CPU runs from the subclock |
| irq_any_pending | input | 1 | Some interrupt request is pending (aborts entry) |
| ext_irq_req | input | 1 | External interrupt request |
| ext_irq_level | input | 4 | Level of the external request |
| int_accept_ok | input | 1 | CPU interrupt enable and level mask permit the request |
| reset_req | input | 1 | External reset request, synchronous |
| por_option | input | 1 | Enables the stabilization wait on reset exit |
| main_tick | input | 1 | One pulse per main oscillator cycle |
| sub_tick | input | 1 | One pulse per subclock cycle |
| main_clk_en | output | 1 | Main oscillator enable |
| sub_clk_en | output | 1 | Subclock oscillator enable (also keeps the watch running) |
| pin_hold | output | 1 | Freeze I/O pins at their last value |
| pin_hiz | output | 1 | Float I/O pins |
| cpu_run | output | 1 | CPU may execute |
| rst_seq_hold | output | 1 | Reset sequence held during the post-reset wait |
| wake_to_isr | output | 1 | 1: take the interrupt on resume; 0: resume at the next instruction |

## Verification
The assertions assume that `reset_req` is a synchronous level that is not asserted while the post-reset synchronizer is still releasing. They also assume that register writes only come from a running CPU, except where the bench deliberately writes while halted to test R11. They take no view on tick rates. The wait-length checks rely on `main_tick` and `sub_tick` being one-cycle enables. The stimulus drives every input on the falling edge and raises each wake source for a single cycle. It also holds `reset_req` low during waits that an interrupt started, so the only wait restart it exercises is the defined one from STOP.

// File: rtl/stopc_pkg.sv
package stopc_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2
  } stopc_state_e;

  localparam int REG_W    = 8;
  localparam int STOP_BIT = 7;
  localparam int PIN_BIT  = 5;
  localparam int WT_LSB   = 2;
  localparam int WT_W     = 2;
  localparam int SEL_W    = 3;
  localparam int NUM_WAIT = 5;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/stopc_rst_sync.sv
module stopc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/stopc_ctrl_reg.sv
module stopc_ctrl_reg
  import stopc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             wr_pin,
  input  logic [WT_W-1:0]  wr_wt,
  output logic             pin_sel,
  output logic [WT_W-1:0]  wt_sel,
  output logic [REG_W-1:0] rdata
);

  logic            pin_q, pin_d;
  logic [WT_W-1:0] wt_q, wt_d;
  logic            upd_en;

  assign upd_en = clr | wr_en;

  always_comb begin
    pin_d = pin_q;
    wt_d  = wt_q;
    if (clr) begin
      pin_d = 1'b0;
      wt_d  = '0;
    end else if (wr_en) begin
      pin_d = wr_pin;
      wt_d  = wr_wt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      wt_q  <= '0;
    end else if (upd_en) begin
      pin_q <= pin_d;
      wt_q  <= wt_d;
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[PIN_BIT]          = pin_q;
    rdata[WT_LSB +: WT_W]   = wt_q;
  end

  assign pin_sel = pin_q;
  assign wt_sel  = wt_q;

endmodule

// File: rtl/stopc_stab_cnt.sv
module stopc_stab_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] last_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign cnt_ce = start | (en & tick);

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = '0;
    end else if (en && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = en & tick & (cnt_q == last_val);

endmodule

// File: rtl/stopc_fsm.sv
module stopc_fsm
  import stopc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_wr,
  input  logic             irq_pending,
  input  logic             sub_active,
  input  logic             reset_req,
  input  logic             wake_irq,
  input  logic             por_option,
  input  logic             int_accept_ok,
  input  logic [WT_W-1:0]  wt_sel,
  input  logic             stab_done,
  output stopc_state_e     state,
  output logic             on_sub,
  output logic             wait_sub,
  output logic             by_reset,
  output logic             to_isr,
  output logic             cnt_start,
  output logic [SEL_W-1:0] wait_sel
);

  stopc_state_e     st_q, st_d;
  logic             on_sub_q, on_sub_d;
  logic             wsub_q, wsub_d;
  logic             byrst_q, byrst_d;
  logic             isr_q, isr_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    st_d      = st_q;
    on_sub_d  = on_sub_q;
    wsub_d    = wsub_q;
    byrst_d   = byrst_q;
    isr_d     = isr_q;
    sel_d     = sel_q;
    cnt_start = 1'b0;
    if (reset_req) begin
      isr_d = 1'b0;
    end
    unique case (st_q)
      ST_RUN: begin
        if (!reset_req && stop_wr && !irq_pending) begin
          st_d     = ST_STOP;
          on_sub_d = sub_active;
          isr_d    = 1'b0;
        end
      end
      ST_STOP: begin
        if (reset_req) begin
          if (por_option) begin
            st_d      = ST_WAIT;
            wsub_d    = 1'b0;
            byrst_d   = 1'b1;
            sel_d     = {1'b0, wt_sel};
            cnt_start = 1'b1;
          end else begin
            st_d    = ST_RUN;
            byrst_d = 1'b0;
          end
        end else if (wake_irq) begin
          st_d      = ST_WAIT;
          byrst_d   = 1'b0;
          isr_d     = int_accept_ok;
          cnt_start = 1'b1;
          if (on_sub_q) begin
            wsub_d = 1'b1;
            sel_d  = SEL_W'(NUM_WAIT - 1);
          end else begin
            wsub_d = 1'b0;
            sel_d  = {1'b0, wt_sel};
          end
        end
      end
      ST_WAIT: begin
        if (stab_done) begin
          st_d    = ST_RUN;
          byrst_d = 1'b0;
        end
      end
      default: begin
        st_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      on_sub_q <= 1'b0;
      wsub_q   <= 1'b0;
      byrst_q  <= 1'b0;
      isr_q    <= 1'b0;
      sel_q    <= '0;
    end else begin
      st_q     <= st_d;
      on_sub_q <= on_sub_d;
      wsub_q   <= wsub_d;
      byrst_q  <= byrst_d;
      isr_q    <= isr_d;
      sel_q    <= sel_d;
    end
  end

  assign state    = st_q;
  assign on_sub   = on_sub_q;
  assign wait_sub = wsub_q;
  assign by_reset = byrst_q;
  assign to_isr   = isr_q;
  assign wait_sel = sel_q;

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import stopc_pkg::*;
#(
  parameter int LVL_W        = 4,
  parameter int WAKE_LVL     = 12,
  parameter int WAIT_EXP_0   = 2,
  parameter int WAIT_EXP_1   = 12,
  parameter int WAIT_EXP_2   = 14,
  parameter int WAIT_EXP_3   = 16,
  parameter int SUB_WAIT_EXP = 15,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             sub_active,
  input  logic             irq_any_pending,
  input  logic             ext_irq_req,
  input  logic [LVL_W-1:0] ext_irq_level,
  input  logic             int_accept_ok,
  input  logic             reset_req,
  input  logic             por_option,
  input  logic             main_tick,
  input  logic             sub_tick,
  output logic             main_clk_en,
  output logic             sub_clk_en,
  output logic             pin_hold,
  output logic             pin_hiz,
  output logic             cpu_run,
  output logic             rst_seq_hold,
  output logic             wake_to_isr
);

  localparam int MAX_EXP = max_int(max_int(max_int(WAIT_EXP_0, WAIT_EXP_1),
                                           max_int(WAIT_EXP_2, WAIT_EXP_3)),
                                   SUB_WAIT_EXP);
  localparam int CNT_W = MAX_EXP + 1;
  localparam int EXP_TBL [NUM_WAIT] = '{WAIT_EXP_0, WAIT_EXP_1, WAIT_EXP_2,
                                        WAIT_EXP_3, SUB_WAIT_EXP};

  logic             rst_sync_n;
  logic             run_wr;
  logic             stop_wr;
  logic             wake_irq;
  logic             pin_sel;
  logic [WT_W-1:0]  wt_sel;
  stopc_state_e     state;
  logic             on_sub;
  logic             wait_sub;
  logic             by_reset;
  logic             cnt_start;
  logic [SEL_W-1:0] wait_sel;
  logic             stab_done;
  logic             stab_tick;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] lim_tbl [NUM_WAIT];
  logic             stop_now;
  logic             wait_now;
  logic             halted;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata[6], reg_wdata[4], reg_wdata[1:0]};

  stopc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  assign run_wr   = reg_wr & (state == ST_RUN);
  assign stop_wr  = run_wr & reg_wdata[STOP_BIT];
  assign wake_irq = ext_irq_req & (ext_irq_level >= LVL_W'(WAKE_LVL));

  stopc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (reset_req),
    .wr_en   (run_wr),
    .wr_pin  (reg_wdata[PIN_BIT]),
    .wr_wt   (reg_wdata[WT_LSB +: WT_W]),
    .pin_sel (pin_sel),
    .wt_sel  (wt_sel),
    .rdata   (reg_rdata)
  );

  stopc_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .stop_wr       (stop_wr),
    .irq_pending   (irq_any_pending),
    .sub_active    (sub_active),
    .reset_req     (reset_req),
    .wake_irq      (wake_irq),
    .por_option    (por_option),
    .int_accept_ok (int_accept_ok),
    .wt_sel        (wt_sel),
    .stab_done     (stab_done),
    .state         (state),
    .on_sub        (on_sub),
    .wait_sub      (wait_sub),
    .by_reset      (by_reset),
    .to_isr        (wake_to_isr),
    .cnt_start     (cnt_start),
    .wait_sel      (wait_sel)
  );

  for (genvar g = 0; g < NUM_WAIT; g++) begin : g_lim
    assign lim_tbl[g] = CNT_W'((64'd1 << EXP_TBL[g]) - 64'd1);
  end

  always_comb begin
    last_val = lim_tbl[NUM_WAIT-1];
    for (int i = 0; i < NUM_WAIT; i++) begin
      if (wait_sel == SEL_W'(i)) begin
        last_val = lim_tbl[i];
      end
    end
  end

  assign stab_tick = wait_sub ? sub_tick : main_tick;

  stopc_stab_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (cnt_start),
    .en       (wait_now),
    .tick     (stab_tick),
    .last_val (last_val),
    .done     (stab_done)
  );

  assign stop_now = (state == ST_STOP);
  assign wait_now = (state == ST_WAIT);
  assign halted   = stop_now | wait_now;

  assign cpu_run      = (state == ST_RUN);
  assign main_clk_en  = cpu_run | (wait_now & ~wait_sub);
  assign sub_clk_en   = cpu_run | wait_now | (stop_now & ~on_sub);
  assign pin_hold     = halted & ~pin_sel;
  assign pin_hiz      = halted & pin_sel;
  assign rst_seq_hold = wait_now & by_reset;

endmodule

// File: rtl/stop_mode_ctrl_chk.sv
module stop_mode_ctrl_chk #(
  parameter int LVL_W    = 4,
  parameter int WAKE_LVL = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             irq_any_pending,
  input logic             ext_irq_req,
  input logic [LVL_W-1:0] ext_irq_level,
  input logic             reset_req,
  input logic             cpu_run,
  input logic             main_clk_en,
  input logic             sub_clk_en,
  input logic             pin_hold,
  input logic             pin_hiz,
  input logic             rst_seq_hold,
  input logic             stop_now
);

  assert_stop_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && reg_wr && reg_wdata[7] && !irq_any_pending && !reset_req)
      |=> (stop_now && !cpu_run));

  assert_pending_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && reg_wr && reg_wdata[7] && irq_any_pending) |=> cpu_run);

  assert_main_off_in_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |-> !main_clk_en);

  assert_all_off_sub_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now && !sub_clk_en) |-> !main_clk_en);

  assert_pin_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_hold && pin_hiz));

  assert_pin_only_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_hold || pin_hiz) |-> !cpu_run);

  assert_low_irq_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now && !reset_req &&
     !(ext_irq_req && (ext_irq_level >= LVL_W'(WAKE_LVL)))) |=> stop_now);

  assert_rst_hold_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seq_hold |-> !cpu_run);

  assert_stop_bit_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7]);

  assert_halted_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_run && reg_wr && !reset_req) |=> $stable(reg_rdata));

endmodule

bind stop_mode_ctrl stop_mode_ctrl_chk #(.LVL_W(LVL_W), .WAKE_LVL(WAKE_LVL)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .reg_wr          (reg_wr),
  .reg_wdata       (reg_wdata),
  .reg_rdata       (reg_rdata),
  .irq_any_pending (irq_any_pending),
  .ext_irq_req     (ext_irq_req),
  .ext_irq_level   (ext_irq_level),
  .reset_req       (reset_req),
  .cpu_run         (cpu_run),
  .main_clk_en     (main_clk_en),
  .sub_clk_en      (sub_clk_en),
  .pin_hold        (pin_hold),
  .pin_hiz         (pin_hiz),
  .rst_seq_hold    (rst_seq_hold),
  .stop_now        (stop_now)
);

// File: tb/stop_mode_ctrl_tb.sv
`timescale 1ns/1ps
module stop_mode_ctrl_tb;

  localparam int E0 = 2, E1 = 3, E2 = 4, E3 = 5, ES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sub_active = 1'b0;
  logic       irq_any_pending = 1'b0;
  logic       ext_irq_req = 1'b0;
  logic [3:0] ext_irq_level = 4'd0;
  logic       int_accept_ok = 1'b0;
  logic       reset_req = 1'b0;
  logic       por_option = 1'b0;
  logic       main_tick = 1'b1;
  logic       sub_tick = 1'b1;
  logic       main_clk_en, sub_clk_en, pin_hold, pin_hiz;
  logic       cpu_run, rst_seq_hold, wake_to_isr;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  stop_mode_ctrl #(
    .WAIT_EXP_0(E0), .WAIT_EXP_1(E1), .WAIT_EXP_2(E2), .WAIT_EXP_3(E3),
    .SUB_WAIT_EXP(ES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sub_active(sub_active),
    .irq_any_pending(irq_any_pending), .ext_irq_req(ext_irq_req),
    .ext_irq_level(ext_irq_level), .int_accept_ok(int_accept_ok),
    .reset_req(reset_req), .por_option(por_option), .main_tick(main_tick),
    .sub_tick(sub_tick), .main_clk_en(main_clk_en), .sub_clk_en(sub_clk_en),
    .pin_hold(pin_hold), .pin_hiz(pin_hiz), .cpu_run(cpu_run),
    .rst_seq_hold(rst_seq_hold), .wake_to_isr(wake_to_isr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int main_exp(input int wt);
    case (wt)
      0: return E0;
      1: return E1;
      2: return E2;
      default: return E3;
    endcase
  endfunction

  // Behavioural reference model: mode 0 = running, 1 = stopped, 2 = waiting
  int m_mode, m_onsub, m_pin, m_wt, m_left, m_wsub, m_byrst, m_isr, m_rs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_mode = 0; m_onsub = 0; m_pin = 0; m_wt = 0;
      m_left = 0; m_wsub = 0; m_byrst = 0; m_isr = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      int old_wt;
      old_wt = m_wt;
      case (m_mode)
        0: begin
          if (reset_req) begin
            m_pin = 0; m_wt = 0; m_isr = 0;
          end else if (reg_wr) begin
            m_pin = reg_wdata[5];
            m_wt  = int'(reg_wdata[3:2]);
            if (reg_wdata[7] && !irq_any_pending) begin
              m_mode = 1; m_onsub = sub_active; m_isr = 0;
            end
          end
        end
        1: begin
          if (reset_req) begin
            m_pin = 0; m_wt = 0; m_isr = 0;
            if (por_option) begin
              m_mode = 2; m_wsub = 0; m_byrst = 1;
              m_left = 1 << main_exp(old_wt);
            end else begin
              m_mode = 0; m_byrst = 0;
            end
          end else if (ext_irq_req && ext_irq_level >= 4'd12) begin
            m_mode = 2; m_byrst = 0; m_isr = int_accept_ok;
            if (m_onsub != 0) begin
              m_wsub = 1; m_left = 1 << ES;
            end else begin
              m_wsub = 0; m_left = 1 << main_exp(m_wt);
            end
          end
        end
        default: begin
          if (reset_req) begin
            m_pin = 0; m_wt = 0; m_isr = 0;
          end
          if ((m_wsub != 0) ? sub_tick : main_tick) begin
            m_left--;
            if (m_left == 0) begin
              m_mode = 0; m_byrst = 0;
            end
          end
        end
      endcase
    end
  end

  // Per-cycle comparison of every output against the model
  always @(negedge clk) begin
    int halted;
    halted = (m_mode != 0) ? 1 : 0;
    chk("R1", "cpu_run", int'(cpu_run), (m_mode == 0) ? 1 : 0);
    chk("R3", "main_clk_en", int'(main_clk_en),
        (m_mode == 0 || (m_mode == 2 && m_wsub == 0)) ? 1 : 0);
    chk("R4", "sub_clk_en", int'(sub_clk_en),
        (m_mode != 1 || m_onsub == 0) ? 1 : 0);
    chk("R5", "pin_hold", int'(pin_hold), (halted != 0 && m_pin == 0) ? 1 : 0);
    chk("R5", "pin_hiz", int'(pin_hiz), (halted != 0 && m_pin != 0) ? 1 : 0);
    chk("R7", "wake_to_isr", int'(wake_to_isr), m_isr);
    chk("R10", "rst_seq_hold", int'(rst_seq_hold), (m_mode == 2 && m_byrst != 0) ? 1 : 0);
    chk("R11", "reg_rdata", int'(reg_rdata), (m_pin << 5) | (m_wt << 2));
  end

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic irq_pulse(input logic [3:0] lvl, input logic req);
    ext_irq_req = req; ext_irq_level = lvl;
    @(negedge clk);
    ext_irq_req = 1'b0; ext_irq_level = 4'd0;
  endtask

  // Counts halted cycles after a one-cycle wake stimulus until cpu_run returns
  task automatic wake_and_count(input bit by_rst, output int n, output int seen_hold,
                                output int seen_main);
    n = 0; seen_hold = 1; seen_main = 1;
    if (by_rst) reset_req = 1'b1; else begin ext_irq_req = 1'b1; ext_irq_level = 4'd12; end
    @(negedge clk);
    reset_req = 1'b0; ext_irq_req = 1'b0; ext_irq_level = 4'd0;
    while (!cpu_run && n < 1000) begin
      if (!rst_seq_hold) seen_hold = 0;
      if (!main_clk_en) seen_main = 0;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, sh, sm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12", "cpu_run", int'(cpu_run), 1);
    chk("R12", "clk_en", int'({main_clk_en, sub_clk_en}), 3);
    chk("R12", "pins", int'({pin_hold, pin_hiz}), 0);
    chk("R12", "rdata", int'(reg_rdata), 0);

    // R11 readback of fields, bit 7 and spare bits read as zero
    wr(8'h2C);
    chk("R11", "rdata after 0x2C", int'(reg_rdata), 8'h2C);
    wr(8'h53);
    chk("R11", "rdata after 0x53", int'(reg_rdata), 8'h00);

    // R1 R3 R5: main-clock stop with hold pins, wait select 01
    wr(8'h84);
    chk("R1", "cpu_run after stop write", int'(cpu_run), 0);
    chk("R3", "main/sub enables", int'({main_clk_en, sub_clk_en}), 1);
    chk("R5", "pin_hold", int'(pin_hold), 1);

    // R6 low-level and unrequested interrupts ignored
    irq_pulse(4'd11, 1'b1);
    irq_pulse(4'd15, 1'b0);
    irq_pulse(4'd3, 1'b1);
    chk("R6", "still stopped (main off)", int'({cpu_run, main_clk_en}), 0);

    // R11 write while halted is ignored
    wr(8'h3C);
    chk("R11", "rdata after halted write", int'(reg_rdata), 8'h04);

    // R7 R8 wake with interrupt accepted, select 01
    int_accept_ok = 1'b1;
    wake_and_count(1'b0, n, sh, sm);
    chk("R8", "wait length sel 01", n, 1 << E1);
    chk("R8", "main enable during wait", sm, 1);
    chk("R7", "wake_to_isr accepted", int'(wake_to_isr), 1);
    int_accept_ok = 1'b0;

    // R8 all four selects, R7 resume without interrupt
    for (int w = 0; w < 4; w++) begin
      wr(8'h80 | 8'(w << 2));
      chk("R7", "wake_to_isr cleared on entry", int'(wake_to_isr), 0);
      wake_and_count(1'b0, n, sh, sm);
      chk("R8", $sformatf("wait length sel %0d", w), n, 1 << main_exp(w));
      chk("R7", "wake_to_isr resume", int'(wake_to_isr), 0);
    end

    // R8 with main tick at half rate
    wr(8'h80);
    main_tick = 1'b0;
    fork
      begin
        wake_and_count(1'b0, n, sh, sm);
      end
      begin
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          main_tick = ~main_tick;
        end
      end
    join
    main_tick = 1'b1;
    chk("R8", "slow tick wait exceeds fast", int'(n > (1 << E0)), 1);

    // R2 pending interrupt aborts entry, fields still loaded
    irq_any_pending = 1'b1;
    wr(8'hA8);
    irq_any_pending = 1'b0;
    chk("R2", "cpu_run stays", int'(cpu_run), 1);
    chk("R2", "fields loaded", int'(reg_rdata), 8'h28);

    // R4 R5 R9 subclock stop, float pins
    sub_active = 1'b1;
    wr(8'hA0);
    sub_active = 1'b0;
    chk("R4", "both enables off", int'({main_clk_en, sub_clk_en}), 0);
    chk("R5", "pin_hiz", int'({pin_hold, pin_hiz}), 1);
    int_accept_ok = 1'b1;
    wake_and_count(1'b0, n, sh, sm);
    int_accept_ok = 1'b0;
    chk("R9", "sub wait length", n, 1 << ES);
    chk("R9", "main enable stayed off", sm, 0);

    // R9 sub tick at half rate, checked by the per-cycle model
    sub_active = 1'b1;
    wr(8'h80);
    sub_active = 1'b0;
    sub_tick = 1'b0;
    fork
      begin
        wake_and_count(1'b0, n, sh, sm);
      end
      begin
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          sub_tick = ~sub_tick;
        end
      end
    join
    sub_tick = 1'b1;
    chk("R9", "slow sub wait longer", int'(n > (1 << ES)), 1);

    // R10 reset exit with power-on option, select 10
    por_option = 1'b1;
    wr(8'h88);
    wake_and_count(1'b1, n, sh, sm);
    chk("R10", "reset wait length", n, 1 << E2);
    chk("R10", "rst_seq_hold throughout", sh, 1);
    chk("R11", "register cleared by reset", int'(reg_rdata), 0);

    // R10 reset exit with option off: immediate resume
    por_option = 1'b0;
    wr(8'h8C);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk("R10", "immediate run", int'(cpu_run), 1);
    chk("R10", "no hold", int'(rst_seq_hold), 0);

    // R11 reset request while running clears register
    wr(8'h2C);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk("R11", "cleared in run", int'(reg_rdata), 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule